// File: doc/BRIEF.md
# Reset Supervisor with Shared Watchdog Timer

This block generates the internal reset of a small controller core. Five events can start a reset: the external reset pin (after deglitching), the end of the power-up delay, a watchdog expiry, a low-supply flag and a wake-up from stop mode. Every accepted event starts a fixed-length reset pulse counted in system clocks. The low-supply flag is different: it forces the reset on at once and holds it for as long as the flag stays high.

A single tick counter does two jobs. After power-up or a delayed wake-up it counts out the startup delay. In normal running it is the watchdog, and software must clear it before it reaches the limit chosen by a 2-bit select. The counter advances only on ticks. The ticks come from one of two tick-enable inputs in the system clock domain, standing in for a crystal-derived clock and an on-chip RC clock. A cause register records the last reset source until software reads it.

Top module: `reset_supervisor`

## Requirements
- R1: The pin request `pin_rst` starts a reset only when it has been sampled high on 4 consecutive clock edges; it fires on the 4th of those edges. Shorter pulses change nothing.
- R2: Any accepted reset event keeps `sys_rst` high for exactly 18 clock cycles after the edge that accepted it.
- R3: With no refresh, the watchdog fires on the Nth counted tick. N comes from `wdt_sel`: 00 gives 5 ticks, 01 gives 15, 10 gives 25 and 11 gives 100.
- R4: A cycle with `wdt_kick` high clears the watchdog count, so counting starts again from zero.
- R5: After `cold_rst`, `sys_rst` stays high through 5 counted ticks and then 18 more cycles, and the cause reads 2 (power-up).
- R6: `tick_src` 0 counts `xtal_tick`; `tick_src` 1 counts `rc_tick`. The tick input that is not selected has no effect.
- R7: While `low_vdd` is high, `sys_rst` is high in the same cycle. It stays high for 18 cycles after the flag drops, and the cause reads 4.
- R8: A `stop_wake` pulse with `stop_dly_en` high holds `sys_rst` for 5 counted ticks plus 18 cycles, and the cause reads 5.
- R9: A `stop_wake` pulse with `stop_dly_en` low starts an 18-cycle reset at once, and the cause reads 5.
- R10: `last_cause` codes are 0 none, 1 pin, 2 power-up, 3 watchdog, 4 low supply and 5 stop wake. A `cause_rd` pulse clears the code to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| cold_rst | input | 1 | Synchronous power-up reset, active high |
| pin_rst | input | 1 | External reset request, active high |
| xtal_tick | input | 1 | Tick enable from the crystal-derived clock |
| rc_tick | input | 1 | Tick enable from the on-chip RC clock |
| tick_src | input | 1 | Selects which tick enable drives the counter |
| wdt_sel | input | 2 | Watchdog limit select |
| wdt_kick | input | 1 | Watchdog refresh strobe |
| stop_wake | input | 1 | Stop-mode wake-up event |
| stop_dly_en | input | 1 | Apply the startup delay on wake-up |
| low_vdd | input | 1 | Low-supply flag |
| cause_rd | input | 1 | Read strobe that clears the cause code |
| sys_rst | output | 1 | Internal reset, active high |
| last_cause | output | 3 | Source of the most recent reset |

## Verification
The tick counter is the state most likely to go wrong unseen. An off-by-one in it, or a wrong limit, moves the rising edge of `sys_rst` by one tick, so the check looks for that edge on the exact cycle that the tick count predicts. A fault in the stretch counter shows up as a reset pulse that is one or more cycles too long or too short, and it is caught by measuring the pulse length after each kind of event. A fault in the filter or the cause register shows up at the ports within a few cycles, either as a reset after a short pin pulse or as a wrong code on `last_cause`.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_PIN  = 3'd1,
        CAUSE_POR  = 3'd2,
        CAUSE_WDOG = 3'd3,
        CAUSE_LOWV = 3'd4,
        CAUSE_STOP = 3'd5
    } cause_e;

    typedef enum logic {
        PH_DELAY = 1'b0,
        PH_RUN   = 1'b1
    } phase_e;

    typedef struct packed {
        logic lowv;
        logic dly_done;
        logic dly_stop;
        logic stop_now;
        logic wdog;
        logic pin;
    } events_t;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // fixed priority: supply > delay end / wake > watchdog > pin
    function automatic cause_e pick_cause(events_t ev);
        if (ev.lowv)          return CAUSE_LOWV;
        else if (ev.dly_done) return ev.dly_stop ? CAUSE_STOP : CAUSE_POR;
        else if (ev.stop_now) return CAUSE_STOP;
        else if (ev.wdog)     return CAUSE_WDOG;
        else if (ev.pin)      return CAUSE_PIN;
        else                  return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/rsup_pin_filter.sv
module rsup_pin_filter #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fire
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] run_q;

    assign fire = pin && (run_q == CW'(LEN - 1));

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (!pin)
            run_q <= '0;
        else if (run_q != CW'(LEN))
            run_q <= run_q + 1'b1;
    end
endmodule

// File: rtl/rsup_chain.sv
module rsup_chain
    import rsup_pkg::*;
#(
    parameter int POR_TICKS = 5,
    parameter int TAP0 = 5,
    parameter int TAP1 = 15,
    parameter int TAP2 = 25,
    parameter int TAP3 = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       kick,
    input  logic       hold,
    input  logic [1:0] tap_sel,
    input  logic       wake,
    input  logic       wake_dly,
    output logic       in_delay,
    output logic       dly_done,
    output logic       dly_stop,
    output logic       wake_now,
    output logic       wd_fire
);
    localparam int MAXT = imax(imax(TAP0, TAP1), imax(imax(TAP2, TAP3), POR_TICKS));
    localparam int CW   = $clog2(MAXT + 1);

    phase_e        phase_q;
    logic          src_stop_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;

    always_comb begin
        unique case (tap_sel)
            2'b00:   lim_m1 = CW'(TAP0 - 1);
            2'b01:   lim_m1 = CW'(TAP1 - 1);
            2'b10:   lim_m1 = CW'(TAP2 - 1);
            default: lim_m1 = CW'(TAP3 - 1);
        endcase
    end

    assign in_delay = (phase_q == PH_DELAY);
    assign dly_stop = src_stop_q;
    assign wake_now = wake && !wake_dly;
    assign dly_done = in_delay && !wake && tick && (cnt_q == CW'(POR_TICKS - 1));
    assign wd_fire  = !in_delay && !wake && !hold && !kick && tick && (cnt_q == lim_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_DELAY;
            src_stop_q <= 1'b0;
            cnt_q      <= '0;
        end else if (wake) begin
            cnt_q <= '0;
            if (wake_dly) begin
                phase_q    <= PH_DELAY;
                src_stop_q <= 1'b1;
            end
        end else if (in_delay) begin
            if (dly_done) begin
                phase_q <= PH_RUN;
                cnt_q   <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (hold || kick || wd_fire)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch
    import rsup_pkg::*;
#(
    parameter int STRETCH = 18
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   trig,
    input  cause_e cause_in,
    input  logic   cause_rd,
    output logic   active,
    output cause_e cause
);
    localparam int SW = $clog2(STRETCH + 1);

    logic [SW-1:0] left_q;

    assign active = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            cause  <= CAUSE_NONE;
        end else begin
            if (trig)
                left_q <= SW'(STRETCH);
            else if (active)
                left_q <= left_q - 1'b1;

            if (trig)
                cause <= cause_in;
            else if (cause_rd)
                cause <= CAUSE_NONE;
        end
    end
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
    import rsup_pkg::*;
#(
    parameter int FILT_LEN  = 4,
    parameter int STRETCH   = 18,
    parameter int POR_TICKS = 5,
    parameter int TAP0      = 5,
    parameter int TAP1      = 15,
    parameter int TAP2      = 25,
    parameter int TAP3      = 100
) (
    input  logic       clk,
    input  logic       cold_rst,
    input  logic       pin_rst,
    input  logic       xtal_tick,
    input  logic       rc_tick,
    input  logic       tick_src,
    input  logic [1:0] wdt_sel,
    input  logic       wdt_kick,
    input  logic       stop_wake,
    input  logic       stop_dly_en,
    input  logic       low_vdd,
    input  logic       cause_rd,
    output logic       sys_rst,
    output logic [2:0] last_cause
);
    logic    tick;
    logic    pin_fire;
    logic    in_delay;
    logic    dly_done;
    logic    dly_stop;
    logic    wake_now;
    logic    wd_fire;
    logic    str_active;
    logic    trig;
    events_t ev;
    cause_e  cause_q;

    assign tick = tick_src ? rc_tick : xtal_tick;

    rsup_pin_filter #(.LEN(FILT_LEN)) u_filt (
        .clk  (clk),
        .rst  (cold_rst),
        .pin  (pin_rst),
        .fire (pin_fire)
    );

    rsup_chain #(
        .POR_TICKS (POR_TICKS),
        .TAP0      (TAP0),
        .TAP1      (TAP1),
        .TAP2      (TAP2),
        .TAP3      (TAP3)
    ) u_chain (
        .clk      (clk),
        .rst      (cold_rst),
        .tick     (tick),
        .kick     (wdt_kick),
        .hold     (str_active),
        .tap_sel  (wdt_sel),
        .wake     (stop_wake),
        .wake_dly (stop_dly_en),
        .in_delay (in_delay),
        .dly_done (dly_done),
        .dly_stop (dly_stop),
        .wake_now (wake_now),
        .wd_fire  (wd_fire)
    );

    always_comb begin
        ev.lowv     = low_vdd;
        ev.dly_done = dly_done;
        ev.dly_stop = dly_stop;
        ev.stop_now = wake_now;
        ev.wdog     = wd_fire;
        ev.pin      = pin_fire;
    end

    assign trig = ev.lowv | ev.dly_done | ev.stop_now | ev.wdog | ev.pin;

    rsup_stretch #(.STRETCH(STRETCH)) u_str (
        .clk      (clk),
        .rst      (cold_rst),
        .trig     (trig),
        .cause_in (pick_cause(ev)),
        .cause_rd (cause_rd),
        .active   (str_active),
        .cause    (cause_q)
    );

    assign sys_rst    = str_active | low_vdd | in_delay;
    assign last_cause = cause_q;
endmodule

// File: rtl/reset_supervisor_chk.sv
module reset_supervisor_chk #(
    parameter int STRETCH = 18
) (
    input logic       clk,
    input logic       cold_rst,
    input logic       pin_rst,
    input logic       low_vdd,
    input logic       stop_wake,
    input logic       cause_rd,
    input logic       sys_rst,
    input logic [2:0] last_cause,
    input logic       pin_fire,
    input logic       wd_fire,
    input logic       trig
);
    logic [7:0] since_trig;

    always_ff @(posedge clk) begin
        if (cold_rst)
            since_trig <= 8'hFF;
        else if (trig)
            since_trig <= 8'd0;
        else if (since_trig != 8'hFF)
            since_trig <= since_trig + 8'd1;
    end

    assert_pin_held_R1: assert property (@(posedge clk) disable iff (cold_rst)
        pin_fire |-> (pin_rst && $past(pin_rst)));

    assert_stretch_len_R2: assert property (@(posedge clk) disable iff (cold_rst)
        $fell(sys_rst) |-> (since_trig == 8'(STRETCH)));

    assert_wdog_cause_R3: assert property (@(posedge clk) disable iff (cold_rst)
        (wd_fire && !low_vdd && !stop_wake) |=> (sys_rst && last_cause == 3'd3));

    assert_cold_hold_R5: assert property (@(posedge clk)
        cold_rst |=> sys_rst);

    assert_lowv_force_R7: assert property (@(posedge clk) disable iff (cold_rst)
        low_vdd |-> sys_rst);

    assert_cause_clear_R10: assert property (@(posedge clk) disable iff (cold_rst)
        (cause_rd && !trig) |=> (last_cause == 3'd0));
endmodule

bind reset_supervisor reset_supervisor_chk #(.STRETCH(STRETCH)) u_chk (
    .clk        (clk),
    .cold_rst   (cold_rst),
    .pin_rst    (pin_rst),
    .low_vdd    (low_vdd),
    .stop_wake  (stop_wake),
    .cause_rd   (cause_rd),
    .sys_rst    (sys_rst),
    .last_cause (last_cause),
    .pin_fire   (pin_fire),
    .wd_fire    (wd_fire),
    .trig       (trig)
);

// File: tb/test_reset_supervisor.sv
`timescale 1ns/1ps
module test_reset_supervisor;

    localparam int STR  = 18;
    localparam int PORT = 5;

    logic       clk = 1'b0;
    logic       cold_rst = 1'b1;
    logic       pin_rst = 1'b0;
    logic       xtal_tick = 1'b1;
    logic       rc_tick = 1'b0;
    logic       tick_src = 1'b0;
    logic [1:0] wdt_sel = 2'b11;
    logic       wdt_kick = 1'b1;
    logic       stop_wake = 1'b0;
    logic       stop_dly_en = 1'b0;
    logic       low_vdd = 1'b0;
    logic       cause_rd = 1'b0;
    logic       sys_rst;
    logic [2:0] last_cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    reset_supervisor i_reset_supervisor (
        .clk(clk), .cold_rst(cold_rst), .pin_rst(pin_rst),
        .xtal_tick(xtal_tick), .rc_tick(rc_tick), .tick_src(tick_src),
        .wdt_sel(wdt_sel), .wdt_kick(wdt_kick), .stop_wake(stop_wake),
        .stop_dly_en(stop_dly_en), .low_vdd(low_vdd), .cause_rd(cause_rd),
        .sys_rst(sys_rst), .last_cause(last_cause)
    );

    // kind 0: pin pulse of arg cycles, exp = reset expected
    // kind 1: watchdog limit select arg, exp = ticks to expiry
    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] arg;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 8'd1, 8'd0},
        '{2'd0, 8'd3, 8'd0},
        '{2'd0, 8'd4, 8'd1},
        '{2'd0, 8'd6, 8'd1},
        '{2'd1, 8'd0, 8'd5},
        '{2'd1, 8'd1, 8'd15},
        '{2'd1, 8'd2, 8'd25},
        '{2'd1, 8'd3, 8'd100}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_cause();
        cause_rd = 1'b1;
        step();
        cause_rd = 1'b0;
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (sys_rst === 1'b1 && n < 300) begin
            n++;
            step();
        end
    endtask

    initial begin
        #(8ns * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        @(negedge clk);
        step();
        check("R5 reset state sys_rst", int'(sys_rst), 1);
        check("R10 reset state cause", int'(last_cause), 0);
        cold_rst = 1'b0;
        steps(PORT + STR - 1);
        check("R5 held through delay and stretch", int'(sys_rst), 1);
        step();
        check("R5 released", int'(sys_rst), 0);
        check("R5 cause power-up", int'(last_cause), 2);
        clear_cause();
        check("R10 cleared by read", int'(last_cause), 0);

        // vector table
        foreach (VECS[k]) begin
            if (VECS[k].kind == 2'd0) begin
                pin_rst = 1'b1;
                steps(int'(VECS[k].arg));
                pin_rst = 1'b0;
                check("R1 pin filter", int'(sys_rst), int'(VECS[k].exp));
                check("R10 pin cause", int'(last_cause), VECS[k].exp != 0 ? 1 : 0);
            end else begin
                wdt_sel  = VECS[k].arg[1:0];
                wdt_kick = 1'b0;
                steps(int'(VECS[k].exp) - 1);
                check("R3 no expiry before limit", int'(sys_rst), 0);
                step();
                check("R3 expiry at limit", int'(sys_rst), 1);
                check("R3 watchdog cause", int'(last_cause), 3);
                wdt_kick = 1'b1;
                wdt_sel  = 2'b11;
            end
            steps(STR + 4);
            clear_cause();
            check("R10 cleared after vector", int'(last_cause), 0);
        end

        // R2: stretch length from a pin event
        pin_rst = 1'b1;
        steps(4);
        pin_rst = 1'b0;
        count_high(n);
        check("R2 stretch length", n, STR);
        clear_cause();

        // R4: refresh restarts the count
        wdt_sel  = 2'b00;
        wdt_kick = 1'b0;
        steps(4);
        wdt_kick = 1'b1;
        step();
        wdt_kick = 1'b0;
        steps(4);
        check("R4 refresh delays expiry", int'(sys_rst), 0);
        step();
        check("R4 expiry after refresh", int'(sys_rst), 1);
        wdt_kick = 1'b1;
        steps(STR + 4);
        clear_cause();

        // R6: tick source select
        tick_src = 1'b1;
        rc_tick  = 1'b0;
        wdt_kick = 1'b0;
        steps(20);
        check("R6 unselected tick ignored", int'(sys_rst), 0);
        rc_tick = 1'b1;
        steps(4);
        check("R6 rc ticks counting", int'(sys_rst), 0);
        step();
        check("R6 rc tick expiry", int'(sys_rst), 1);
        wdt_kick = 1'b1;
        tick_src = 1'b0;
        rc_tick  = 1'b0;
        wdt_sel  = 2'b11;
        steps(STR + 4);
        clear_cause();

        // R7: low supply
        low_vdd = 1'b1;
        #1;
        check("R7 immediate force", int'(sys_rst), 1);
        @(negedge clk);
        steps(3);
        check("R7 low supply cause", int'(last_cause), 4);
        low_vdd = 1'b0;
        count_high(n);
        check("R7 hold after drop", n, STR);
        clear_cause();

        // R8: wake with delay
        stop_dly_en = 1'b1;
        stop_wake   = 1'b1;
        step();
        stop_wake = 1'b0;
        count_high(n);
        check("R8 delayed wake length", n, PORT + STR);
        check("R8 wake cause", int'(last_cause), 5);
        clear_cause();

        // R9: wake without delay
        stop_dly_en = 1'b0;
        stop_wake   = 1'b1;
        step();
        stop_wake = 1'b0;
        count_high(n);
        check("R9 direct wake length", n, STR);
        check("R9 wake cause", int'(last_cause), 5);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule